// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block sits between a processor core and its interrupt sources. It holds the core's current priority level (0 to 3) and arbitrates among request lines from peripherals, debug-port sources, a non-maskable source and a low-priority software source. A request is acknowledged only when its level is at least the current level. When a request is accepted, the block saves the old level on a small nesting stack and raises the current level. It also outputs the source's vector number and the fetch address of that vector's table entry.

Every request is caught in a sticky pending latch. A request that cannot be served yet therefore waits until returns, or a level load by the core, lower the current level far enough. A return strobe restores the level that was in force before the most recent acceptance. A load strobe lets the core write the level directly. The table base is an input. A data-execution flag is sampled at acceptance and travels with the acknowledge, so the fetch unit can target the data-memory copy of the table.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset the current level is 3, no acknowledge is issued, no pending request exists and the overflow flag is low.
- R2: A peripheral source, configured by the 2-bit field `per_lvl_i[2p+1:2p]` and the bit `per_en_i[p]`, is eligible only when it is enabled and its field is 0, 1 or 2. A field of 3 or a clear enable means the source is never acknowledged.
- R3: A debug source, configured by `dbg_lvl_i[2d+1:2d]` and `dbg_en_i[d]`, is eligible only when it is enabled and its field is 1, 2 or 3. A field of 0 or a clear enable means the source is never acknowledged.
- R4: A pending, eligible source is accepted only if its level is greater than or equal to the current level. A source with a higher level preempts a running handler.
- R5: When several sources are acceptable, the highest level wins and a tie goes to the lowest source index. Index 0 is the non-maskable source, index 1 the software source, indices 2 to 2+N_DBG-1 the debug sources, and the peripherals follow in order.
- R6: On acceptance the current level becomes the winner's level plus one, saturating at 3. The non-maskable source has the fixed level 3.
- R7: The software source has the fixed level 0. Its acceptance leaves the current level unchanged, although it still pushes the nesting stack.
- R8: A return strobe pops the stack into the current level. In a cycle with a return, nothing is accepted and any level load is ignored. A return on an empty stack changes nothing.
- R9: Each source's request sets a sticky pending bit, whatever its configuration. The bit clears when that source is acknowledged, but a request arriving in the same cycle keeps it set.
- R10: The acknowledge is a one-cycle pulse on the clock edge after the pending bit is captured. It carries the winner's vector from its `src_vec_i` slice, the address `tbl_base_i + 2*vector` modulo 2^ADDR_W, and `data_mode_i` as sampled on that edge.
- R11: The stack holds DEPTH saved levels. While it is full, no request is accepted, and `ovf_o` is high whenever an acceptable request exists.
- R12: A level load, when no return is present, writes `lvl_wdata_i` into the current level and blocks acceptance in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| per_req_i | input | N_PER | Peripheral request lines |
| per_lvl_i | input | 2*N_PER | Peripheral level fields |
| per_en_i | input | N_PER | Peripheral enables |
| dbg_req_i | input | N_DBG | Debug-port request lines |
| dbg_lvl_i | input | 2*N_DBG | Debug level fields |
| dbg_en_i | input | N_DBG | Debug enables |
| nmi_req_i | input | 1 | Non-maskable request |
| swi_req_i | input | 1 | Low-priority software request |
| src_vec_i | input | (N_PER+N_DBG+2)*VEC_W | Vector number per source index |
| tbl_base_i | input | ADDR_W | Vector table base address |
| data_mode_i | input | 1 | Table lives in data memory |
| rti_i | input | 1 | Return-from-interrupt strobe |
| lvl_wr_i | input | 1 | Current-level load strobe |
| lvl_wdata_i | input | 2 | Level to load |
| ack_o | output | 1 | Acknowledge pulse |
| ack_vec_o | output | VEC_W | Accepted vector number |
| ack_addr_o | output | ADDR_W | Vector fetch address |
| ack_data_o | output | 1 | Fetch from data memory |
| cur_lvl_o | output | 2 | Current priority level |
| ovf_o | output | 1 | Acceptable request blocked by a full stack |

## Verification
The bench builds the block with five peripherals, two debug sources, a stack depth of 3, 6-bit vectors and a 12-bit address. The shallow stack lets three nested level-3 acceptances reach the overflow condition within a few cycles. With nine sources, ties, preemption and disabled sources can all be exercised at once. The 12-bit address with a high table base makes the modulo wrap of the fetch address reachable from random vectors and bases.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_TOP = 2'd3;
  localparam lvl_t LVL_SWI = 2'd0;

  function automatic lvl_t lvl_raise(input lvl_t l);
    return (l == LVL_TOP) ? LVL_TOP : lvl_t'(l + 2'd1);
  endfunction
endpackage

// File: rtl/nest_irq_src_map.sv
module nest_irq_src_map
  import nest_irq_pkg::*;
#(
  parameter int N_PER = 8,
  parameter int N_DBG = 2
) (
  input  logic [N_PER-1:0]             per_req_i,
  input  logic [2*N_PER-1:0]           per_lvl_i,
  input  logic [N_PER-1:0]             per_en_i,
  input  logic [N_DBG-1:0]             dbg_req_i,
  input  logic [2*N_DBG-1:0]           dbg_lvl_i,
  input  logic [N_DBG-1:0]             dbg_en_i,
  input  logic                         nmi_req_i,
  input  logic                         swi_req_i,
  output logic [N_PER+N_DBG+2-1:0]     req_o,
  output logic [N_PER+N_DBG+2-1:0]     ok_o,
  output lvl_t [N_PER+N_DBG+2-1:0]     lvl_o
);
  localparam int DBG_BASE = 2;
  localparam int PER_BASE = DBG_BASE + N_DBG;

  assign req_o[0] = nmi_req_i;
  assign ok_o[0]  = 1'b1;
  assign lvl_o[0] = LVL_TOP;
  assign req_o[1] = swi_req_i;
  assign ok_o[1]  = 1'b1;
  assign lvl_o[1] = LVL_SWI;

  for (genvar g = 0; g < N_DBG; g++) begin : g_dbg
    lvl_t l;
    assign l                   = dbg_lvl_i[2*g +: 2];
    assign req_o[DBG_BASE + g] = dbg_req_i[g];
    assign lvl_o[DBG_BASE + g] = l;
    assign ok_o[DBG_BASE + g]  = dbg_en_i[g] && (l != 2'd0);
  end

  for (genvar g = 0; g < N_PER; g++) begin : g_per
    lvl_t l;
    assign l                   = per_lvl_i[2*g +: 2];
    assign req_o[PER_BASE + g] = per_req_i[g];
    assign lvl_o[PER_BASE + g] = l;
    assign ok_o[PER_BASE + g]  = per_en_i[g] && (l != LVL_TOP);
  end
endmodule

// File: rtl/nest_irq_arbiter.sv
module nest_irq_arbiter
  import nest_irq_pkg::*;
#(
  parameter int N  = 12,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] ok_i,
  input  lvl_t [N-1:0] lvl_i,
  input  lvl_t         cur_i,
  output logic         found_o,
  output logic [IW-1:0] idx_o,
  output lvl_t         win_lvl_o
);
  // descending scan with >= leaves the lowest index on a level tie
  always_comb begin
    found_o   = 1'b0;
    idx_o     = '0;
    win_lvl_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i] && ok_i[i] && (lvl_i[i] >= cur_i) &&
          (!found_o || (lvl_i[i] >= win_lvl_o))) begin
        found_o   = 1'b1;
        idx_o     = IW'(i);
        win_lvl_o = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/nest_irq_stack.sv
module nest_irq_stack
  import nest_irq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PW    = $clog2(DEPTH + 1),
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic pop_i,
  input  lvl_t din_i,
  output lvl_t top_o,
  output logic full_o,
  output logic empty_o
);
  lvl_t           mem_q [DEPTH];
  logic [PW-1:0]  ptr_q;
  logic [PW-1:0]  top_idx;

  assign full_o  = (ptr_q == PW'(DEPTH));
  assign empty_o = (ptr_q == '0);
  assign top_idx = ptr_q - 1'b1;
  assign top_o   = mem_q[top_idx[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= LVL_TOP;
    end else if (push_i) begin
      mem_q[ptr_q[AW-1:0]] <= din_i;
      ptr_q                <= ptr_q + 1'b1;
    end else if (pop_i) begin
      ptr_q <= ptr_q - 1'b1;
    end
  end

  // R11: the controller must never push into a full stack
  a_r11_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R8: a pop only happens with a saved level present
  a_r8_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  a_r11_no_push_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nest_irq_pkg::*;
#(
  parameter int N_PER  = 8,
  parameter int N_DBG  = 2,
  parameter int DEPTH  = 4,
  parameter int VEC_W  = 7,
  parameter int ADDR_W = 16
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [N_PER-1:0]                    per_req_i,
  input  logic [2*N_PER-1:0]                  per_lvl_i,
  input  logic [N_PER-1:0]                    per_en_i,
  input  logic [N_DBG-1:0]                    dbg_req_i,
  input  logic [2*N_DBG-1:0]                  dbg_lvl_i,
  input  logic [N_DBG-1:0]                    dbg_en_i,
  input  logic                                nmi_req_i,
  input  logic                                swi_req_i,
  input  logic [(N_PER+N_DBG+2)*VEC_W-1:0]    src_vec_i,
  input  logic [ADDR_W-1:0]                   tbl_base_i,
  input  logic                                data_mode_i,
  input  logic                                rti_i,
  input  logic                                lvl_wr_i,
  input  logic [1:0]                          lvl_wdata_i,
  output logic                                ack_o,
  output logic [VEC_W-1:0]                    ack_vec_o,
  output logic [ADDR_W-1:0]                   ack_addr_o,
  output logic                                ack_data_o,
  output logic [1:0]                          cur_lvl_o,
  output logic                                ovf_o
);
  localparam int N       = N_PER + N_DBG + 2;
  localparam int IW      = (N > 1) ? $clog2(N) : 1;
  localparam int SWI_IDX = 1;

  logic [N-1:0]  src_req, src_ok, pend_q, clr;
  lvl_t [N-1:0]  src_lvl;
  logic          found;
  logic [IW-1:0] win_idx;
  lvl_t          win_lvl, cur_q, cur_d, stk_top;
  logic          stk_full, stk_empty, accept, pop;
  logic [VEC_W-1:0] win_vec;
  lvl_t          ack_lvl_q;
  logic          ack_swi_q;

  nest_irq_src_map #(.N_PER(N_PER), .N_DBG(N_DBG)) u_map (
    .per_req_i, .per_lvl_i, .per_en_i,
    .dbg_req_i, .dbg_lvl_i, .dbg_en_i,
    .nmi_req_i, .swi_req_i,
    .req_o(src_req), .ok_o(src_ok), .lvl_o(src_lvl)
  );

  nest_irq_arbiter #(.N(N), .IW(IW)) u_arb (
    .pend_i(pend_q), .ok_i(src_ok), .lvl_i(src_lvl), .cur_i(cur_q),
    .found_o(found), .idx_o(win_idx), .win_lvl_o(win_lvl)
  );

  assign accept = found && !rti_i && !lvl_wr_i && !stk_full;
  assign pop    = rti_i && !stk_empty;

  nest_irq_stack #(.DEPTH(DEPTH)) u_stk (
    .clk_i, .rst_ni,
    .push_i(accept), .pop_i(pop), .din_i(cur_q),
    .top_o(stk_top), .full_o(stk_full), .empty_o(stk_empty)
  );

  always_comb begin
    cur_d = cur_q;
    if (rti_i) begin
      if (!stk_empty) cur_d = stk_top;
    end else if (lvl_wr_i) begin
      cur_d = lvl_wdata_i;
    end else if (accept && (win_idx != IW'(SWI_IDX))) begin
      cur_d = lvl_raise(win_lvl);
    end
  end

  always_comb begin
    clr = '0;
    if (accept) clr[win_idx] = 1'b1;
  end

  assign win_vec = src_vec_i[win_idx*VEC_W +: VEC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q      <= LVL_TOP;
      pend_q     <= '0;
      ack_o      <= 1'b0;
      ack_vec_o  <= '0;
      ack_addr_o <= '0;
      ack_data_o <= 1'b0;
      ack_lvl_q  <= '0;
      ack_swi_q  <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      pend_q <= (pend_q & ~clr) | src_req;
      ack_o  <= accept;
      if (accept) begin
        ack_vec_o  <= win_vec;
        ack_addr_o <= tbl_base_i + ADDR_W'({win_vec, 1'b0});
        ack_data_o <= data_mode_i;
        ack_lvl_q  <= win_lvl;
        ack_swi_q  <= (win_idx == IW'(SWI_IDX));
      end
    end
  end

  assign cur_lvl_o = cur_q;
  assign ovf_o     = found && stk_full;

  // R4: an accepted level never lies below the level in force before it
  a_r4_no_low_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ack_lvl_q >= $past(cur_lvl_o));
  // R6: a non-software acceptance below the top leaves the core above it
  a_r6_level_raised: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !ack_swi_q && ack_lvl_q != LVL_TOP) |-> cur_lvl_o > ack_lvl_q);
  // R7: software acceptance keeps the level
  a_r7_swi_keeps_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && ack_swi_q) |-> cur_lvl_o == $past(cur_lvl_o));
  // R8: no acknowledge follows a return cycle
  a_r8_rti_blocks_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rti_i |=> !ack_o);
  // R12: no acknowledge follows a load cycle
  a_r12_load_blocks_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_wr_i |=> !ack_o);
endmodule

// File: tb/nest_irq_ctrl_tb_top.sv
module nest_irq_ctrl_tb_top;
  localparam int N_PER  = 5;
  localparam int N_DBG  = 2;
  localparam int DEPTH  = 3;
  localparam int VEC_W  = 6;
  localparam int ADDR_W = 12;
  localparam int N      = N_PER + N_DBG + 2;
  localparam int PB     = 2 + N_DBG;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N_PER-1:0]   per_req_i = '0;
  logic [2*N_PER-1:0] per_lvl_i = '0;
  logic [N_PER-1:0]   per_en_i = '0;
  logic [N_DBG-1:0]   dbg_req_i = '0;
  logic [2*N_DBG-1:0] dbg_lvl_i = '0;
  logic [N_DBG-1:0]   dbg_en_i = '0;
  logic nmi_req_i = 1'b0, swi_req_i = 1'b0;
  logic [N*VEC_W-1:0] src_vec_i;
  logic [ADDR_W-1:0]  tbl_base_i = 12'hF80;
  logic data_mode_i = 1'b0, rti_i = 1'b0, lvl_wr_i = 1'b0;
  logic [1:0] lvl_wdata_i = '0;
  logic ack_o, ack_data_o, ovf_o;
  logic [VEC_W-1:0] ack_vec_o;
  logic [ADDR_W-1:0] ack_addr_o;
  logic [1:0] cur_lvl_o;

  always #4 clk_i = ~clk_i;

  nest_irq_ctrl #(.N_PER(N_PER), .N_DBG(N_DBG), .DEPTH(DEPTH),
                  .VEC_W(VEC_W), .ADDR_W(ADDR_W)) dut_i (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int vec_of(input int i);
    return (i * 13 + 5) % 64;
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_vec
    assign src_vec_i[g*VEC_W +: VEC_W] = VEC_W'(vec_of(g));
  end

  // behavioural reference
  bit [N-1:0] m_pend;
  int m_cur, m_vec, m_addr;
  bit m_ack, m_data;
  int m_stk[$];

  function automatic int s_lvl(input int i);
    if (i == 0) return 3;
    if (i == 1) return 0;
    if (i < PB) return int'(dbg_lvl_i[2*(i-2) +: 2]);
    return int'(per_lvl_i[2*(i-PB) +: 2]);
  endfunction

  function automatic bit s_ok(input int i);
    if (i < 2) return 1;
    if (i < PB) return dbg_en_i[i-2] && s_lvl(i) != 0;
    return per_en_i[i-PB] && s_lvl(i) != 3;
  endfunction

  function automatic int pick();
    int w = -1, bl = -1;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && s_ok(i) && s_lvl(i) >= m_cur && s_lvl(i) > bl) begin
        w = i; bl = s_lvl(i);
      end
    return w;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pend = '0; m_cur = 3; m_ack = 0; m_stk.delete();
      m_vec = 0; m_addr = 0; m_data = 0;
    end else begin
      int w;
      bit [N-1:0] rq;
      w = pick();
      m_ack = 0;
      if (rti_i) begin
        if (m_stk.size() > 0) m_cur = m_stk.pop_back();
      end else if (lvl_wr_i) begin
        m_cur = int'(lvl_wdata_i);
      end else if (w >= 0 && m_stk.size() < DEPTH) begin
        m_stk.push_back(m_cur);
        m_ack = 1;
        m_vec = vec_of(w);
        m_addr = (int'(tbl_base_i) + 2 * m_vec) % (1 << ADDR_W);
        m_data = data_mode_i;
        if (w != 1) m_cur = (s_lvl(w) == 3) ? 3 : s_lvl(w) + 1;
        m_pend[w] = 0;
      end
      rq = {per_req_i, dbg_req_i, swi_req_i, nmi_req_i};
      m_pend |= rq;
    end
  end

  always begin
    @(posedge clk_i);
    #1;
    if (rst_ni && !done) begin
      bit m_ovf;
      m_ovf = (pick() >= 0) && (m_stk.size() == DEPTH);
      chk(ack_o == m_ack, "R2 R3 R4 R5 R9 ack", ack_o, m_ack);
      if (m_ack && ack_o) begin
        chk(ack_vec_o == VEC_W'(m_vec), "R5 R10 vector", ack_vec_o, m_vec);
        chk(ack_addr_o == ADDR_W'(m_addr), "R10 address", ack_addr_o, m_addr);
        chk(ack_data_o == m_data, "R10 data flag", ack_data_o, m_data);
      end
      chk(cur_lvl_o == 2'(m_cur), "R6 R7 R8 R12 level", cur_lvl_o, m_cur);
      chk(ovf_o == m_ovf, "R11 overflow", ovf_o, m_ovf);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask
  task automatic pulse_per(input int p);
    @(negedge clk_i); per_req_i[p] = 1'b1;
    @(negedge clk_i); per_req_i[p] = 1'b0;
  endtask
  task automatic do_rti();
    @(negedge clk_i); rti_i = 1'b1;
    @(negedge clk_i); rti_i = 1'b0;
  endtask
  task automatic do_load(input logic [1:0] l);
    @(negedge clk_i); lvl_wr_i = 1'b1; lvl_wdata_i = l;
    @(negedge clk_i); lvl_wr_i = 1'b0;
  endtask

  initial begin
    #800000;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    per_en_i  = '1;
    per_lvl_i = {2'd2, 2'd2, 2'd2, 2'd0, 2'd1};
    dbg_en_i  = 2'b11;
    dbg_lvl_i = {2'd3, 2'd0};
    tick(3);
    chk(cur_lvl_o == 2'd3, "R1 reset level", cur_lvl_o, 3);
    chk(ack_o == 1'b0, "R1 reset ack", ack_o, 0);
    chk(ovf_o == 1'b0, "R1 reset overflow", ovf_o, 0);
    rst_ni = 1'b1;
    tick(2);
    // R4: level 1 request at level 3 is held
    pulse_per(0);
    tick(3);
    chk(ack_o == 1'b0 && cur_lvl_o == 2'd3, "R4 held below level", cur_lvl_o, 3);
    // R12 then R9: load to 0 releases the latched request
    do_load(2'd0);
    chk(cur_lvl_o == 2'd0, "R12 level load", cur_lvl_o, 0);
    tick(1);
    chk(ack_o == 1'b1, "R9 pending serviced", ack_o, 1);
    chk(cur_lvl_o == 2'd2, "R6 level raised", cur_lvl_o, 2);
    chk(ack_vec_o == VEC_W'(vec_of(PB)), "R10 vector", ack_vec_o, vec_of(PB));
    chk(ack_addr_o == ADDR_W'(12'hF80 + 2 * vec_of(PB)), "R10 address", ack_addr_o,
        12'hF80 + 2 * vec_of(PB));
    pulse_per(1);            // level 0, stays pending
    tick(2);
    pulse_per(2);            // level 2 preempts
    tick(2);
    chk(cur_lvl_o == 2'd3, "R4 preempt", cur_lvl_o, 3);
    do_rti(); tick(1);
    do_rti(); tick(3);
    chk(cur_lvl_o == 2'd1, "R8 R9 restore then pending", cur_lvl_o, 1);
    do_rti(); tick(2);
    @(negedge clk_i); swi_req_i = 1'b1;
    @(negedge clk_i); swi_req_i = 1'b0;
    tick(1);
    chk(cur_lvl_o == 2'd0, "R7 software keeps level", cur_lvl_o, 0);
    do_rti(); tick(2);
    // R5: simultaneous level-2 requests, lowest index first
    @(negedge clk_i); per_req_i[3] = 1'b1; per_req_i[4] = 1'b1;
    @(negedge clk_i); per_req_i = '0;
    tick(1);
    chk(ack_vec_o == VEC_W'(vec_of(PB + 3)), "R5 tie lowest index", ack_vec_o, vec_of(PB + 3));
    do_rti(); tick(3);
    do_rti(); tick(2);
    // R2 R3: disabled or out-of-range sources never acknowledged
    per_en_i[0] = 1'b0;
    per_lvl_i[5:4] = 2'd3;
    @(negedge clk_i); per_req_i[0] = 1'b1; per_req_i[2] = 1'b1; dbg_req_i[0] = 1'b1;
    @(negedge clk_i); per_req_i = '0; dbg_req_i = '0;
    tick(4);
    chk(cur_lvl_o == 2'd0 && ack_o == 1'b0, "R2 R3 ignored sources", cur_lvl_o, 0);
    // R11: fill the stack with level-3 acceptances
    @(negedge clk_i); dbg_req_i[1] = 1'b1;
    @(negedge clk_i); dbg_req_i = '0; nmi_req_i = 1'b1;
    tick(5);
    nmi_req_i = 1'b0;
    chk(ovf_o == 1'b1, "R11 overflow flagged", ovf_o, 1);
    // R8: return and load together, return wins
    @(negedge clk_i); rti_i = 1'b1; lvl_wr_i = 1'b1; lvl_wdata_i = 2'd1;
    @(negedge clk_i); rti_i = 1'b0; lvl_wr_i = 1'b0;
    repeat (8) do_rti();
    tick(2);
    do_rti(); tick(2);       // R8: empty-stack return
    // random phase
    for (int c = 0; c < 600; c++) begin
      @(negedge clk_i);
      per_req_i   = ($urandom % 4 == 0) ? N_PER'($urandom) : '0;
      dbg_req_i   = ($urandom % 8 == 0) ? N_DBG'($urandom) : '0;
      nmi_req_i   = ($urandom % 25 == 0);
      swi_req_i   = ($urandom % 12 == 0);
      rti_i       = ($urandom % 4 == 0);
      lvl_wr_i    = ($urandom % 15 == 0);
      lvl_wdata_i = 2'($urandom);
      data_mode_i = 1'($urandom);
      if ($urandom % 30 == 0) begin
        per_lvl_i  = (2*N_PER)'($urandom);
        per_en_i   = N_PER'($urandom);
        dbg_lvl_i  = (2*N_DBG)'($urandom);
        dbg_en_i   = N_DBG'($urandom);
        tbl_base_i = ADDR_W'($urandom);
      end
    end
    @(negedge clk_i);
    per_req_i = '0; dbg_req_i = '0; nmi_req_i = 0; swi_req_i = 0; rti_i = 0; lvl_wr_i = 0;
    tick(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule